// File: doc/BRIEF.md
# Valley-Held Flyback Gate Pulse Generator

This block creates the switching pulse for a voltage-mode flyback controller. A free-running counter stands in for the sawtooth. Each switching cycle begins at the counter's valley (zero). The gate turns on there and stays on until the counter reaches the control word. The counted on-time is also capped at a fixed fraction of the nominal period. A digitized overcurrent flag can end the pulse early, but the flag is disregarded for a short blanking interval just after turn-on. Each cycle gives at most one pulse.

A zero-crossing flag from the auxiliary winding shows that the transformer has given up its energy. After a pulse ends, the counter may run through its period, but it waits at the valley until that flag has been seen. As a result, a heavily loaded converter slows down and oscillates on its own demagnetization timing. When `DEMAG_DET` is 0, the demagnetization gating is removed and the counter free-runs. Any overvoltage sensing that shares that pin is then unavailable as well.

Both asynchronous flags pass through two-flop synchronizers. A strobe pulses for one clock each time a cycle starts.

Top module: `pwm_demag_gate`

## Requirements
- R1: While reset is asserted, `gate` and `cyc_stb` are 0 and the demagnetization record reads "complete". The first cycle after reset therefore starts at the first rising clock edge where `enable` is 1, with no zero-crossing needed.
- R2: A cycle starts when the counter is at zero, `enable` is 1 and demagnetization is complete. `cyc_stb` is 1 for exactly the one clock after that edge. If demagnetization completes before the counter wraps, successive starts are `PERIOD` clocks apart.
- R3: The gate turns on together with `cyc_stb` and stays high for `ctrl_word` clocks. The control word is compared live against the counter. If `ctrl_word` is 0, the strobe still pulses but no gate pulse appears.
- R4: The gate never stays high for more than `PERIOD*DMAX_NUM/DMAX_DEN` clocks. With the defaults this is 160 clocks, whatever the control word.
- R5: A synchronized overcurrent flag that is seen after blanking ends the pulse at the next edge. If raw `oc_async` is raised in the pulse's 20th high cycle, the pulse is 22 cycles wide.
- R6: Overcurrent is ignored during the first `BLANK_CYC` gate-high cycles. If the flag is held high from before the start, the pulse is exactly `BLANK_CYC+1` cycles wide.
- R7: Once a pulse has ended, the gate stays low until the next `cyc_stb`, even if the overcurrent flag returns to 0.
- R8: After a pulse, the counter holds at zero and no new cycle starts until a zero-crossing has been seen with the gate low.
- R9: The zero-crossing indication is latched. A one-clock raw pulse is enough, and it starts the next cycle on the fourth edge after it is applied. Zero-crossing input that arrives while the gate is high is ignored.
- R10: While `enable` is 0, `gate` and `cyc_stb` are 0 from the next edge on and the counter returns to zero. When `enable` returns to 1 and demagnetization is complete, a cycle starts at the next edge.
- R11: `oc_async` and `zc_async` reach the logic through `SYNC_STAGES` (2) flops. Their effects appear exactly two clocks later than for an in-clock-domain signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low forces gate off and counter to valley |
| ctrl_word | input | CNT_W | On-time target in clocks from the regulation loop |
| oc_async | input | 1 | Overcurrent comparator output, asynchronous |
| zc_async | input | 1 | Winding-below-threshold comparator output, asynchronous |
| gate | output | 1 | Power switch gate command |
| cyc_stb | output | 1 | One-clock strobe at each cycle start |

## Verification
On every clock, the bound checker confirms the following:
- The strobe lasts a single clock.
- A gate rise always coincides with a strobe.
- The gate-high count never passes the duty limit.
- A pulse survives the blanking interval when the compare has not yet matched.
- The counter stays at the valley while demagnetization is pending.
- Disable clears the outputs.

Some behaviours need sequences that only the bench's scenarios drive, with a behavioural model compared each clock:
- the exact pulse widths from the control word, overcurrent and blanking;
- the two-clock synchronizer latency;
- the latching of a one-clock zero-crossing;
- the rejection of zero-crossings during on-time;
- the nominal period when demagnetization is early.

// File: rtl/pwm_demag_pkg.sv
package pwm_demag_pkg;

   // Largest gate-high count allowed: fraction num/den of the nominal period.
   function automatic int duty_limit(input int period, input int num, input int den);
      return (period * num) / den;
   endfunction

endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/pwm_saw.sv
module pwm_saw #(
   parameter int CNT_W  = 8,
   parameter int PERIOD = 200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             release_ok,
   output logic [CNT_W-1:0] cnt,
   output logic             start
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic at_valley;
   assign at_valley = (cnt == '0);
   assign start     = enable && at_valley && release_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (!enable)                 cnt <= '0;
      else if (at_valley && !release_ok) cnt <= '0;
      else if (cnt == LAST)             cnt <= '0;
      else                              cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pwm_demag_track.sv
module pwm_demag_track #(
   parameter bit DET_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic zc_sync,
   input  logic gate,
   input  logic start,
   output logic done
);
   generate
      if (DET_EN) begin : g_track
         logic done_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                done_q <= 1'b1;
            else if (start)            done_q <= 1'b0;
            else if (zc_sync && !gate) done_q <= 1'b1;
         end
         assign done = done_q;
      end else begin : g_bypass
         assign done = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/pwm_gate_latch.sv
module pwm_gate_latch #(
   parameter int CNT_W     = 8,
   parameter int DUTY_LIM  = 160,
   parameter int BLANK_CYC = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             start,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] ctrl_word,
   input  logic             oc_sync,
   output logic             gate,
   output logic             cyc_stb
);
   localparam logic [CNT_W-1:0] LIM_V   = CNT_W'(DUTY_LIM);
   localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CYC);

   logic cmp_end, lim_end, oc_end, stop;
   assign cmp_end = (cnt >= ctrl_word);
   assign lim_end = (cnt >= LIM_V);
   assign oc_end  = oc_sync && (cnt > BLANK_V);
   assign stop    = cmp_end || lim_end || oc_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate    <= 1'b0;
         cyc_stb <= 1'b0;
      end else begin
         cyc_stb <= start;
         if (!enable)          gate <= 1'b0;
         else if (start)       gate <= (ctrl_word != '0);
         else if (gate && stop) gate <= 1'b0;
      end
   end
endmodule

// File: rtl/pwm_demag_gate.sv
module pwm_demag_gate #(
   parameter int CNT_W       = 8,
   parameter int PERIOD      = 200,
   parameter int DMAX_NUM    = 4,
   parameter int DMAX_DEN    = 5,
   parameter int BLANK_CYC   = 6,
   parameter int SYNC_STAGES = 2,
   parameter bit DEMAG_DET   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] ctrl_word,
   input  logic             oc_async,
   input  logic             zc_async,
   output logic             gate,
   output logic             cyc_stb
);
   localparam int DUTY_LIM = pwm_demag_pkg::duty_limit(PERIOD, DMAX_NUM, DMAX_DEN);

   generate
      if (PERIOD < 3 || PERIOD > (1 << CNT_W)) begin : g_bad_period
         $error("pwm_demag_gate: PERIOD out of range for CNT_W");
      end
      if (DMAX_DEN <= 0 || DMAX_NUM <= 0 || DMAX_NUM >= DMAX_DEN) begin : g_bad_duty
         $error("pwm_demag_gate: duty fraction must lie strictly between 0 and 1");
      end
      if (BLANK_CYC < 0 || BLANK_CYC >= DUTY_LIM) begin : g_bad_blank
         $error("pwm_demag_gate: blanking must be shorter than the duty limit");
      end
   endgenerate

   logic             oc_s, zc_s, dmg_done, start;
   logic [CNT_W-1:0] cnt;

   pwm_sync #(.STAGES(SYNC_STAGES)) u_sync_oc (
      .clk(clk), .rst_n(rst_n), .d(oc_async), .q(oc_s));

   pwm_sync #(.STAGES(SYNC_STAGES)) u_sync_zc (
      .clk(clk), .rst_n(rst_n), .d(zc_async), .q(zc_s));

   pwm_saw #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_saw (
      .clk(clk), .rst_n(rst_n), .enable(enable), .release_ok(dmg_done),
      .cnt(cnt), .start(start));

   pwm_demag_track #(.DET_EN(DEMAG_DET)) u_dmg (
      .clk(clk), .rst_n(rst_n), .zc_sync(zc_s), .gate(gate),
      .start(start), .done(dmg_done));

   pwm_gate_latch #(.CNT_W(CNT_W), .DUTY_LIM(DUTY_LIM), .BLANK_CYC(BLANK_CYC)) u_gate (
      .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .cnt(cnt),
      .ctrl_word(ctrl_word), .oc_sync(oc_s), .gate(gate), .cyc_stb(cyc_stb));
endmodule

// File: rtl/pwm_gate_chk.sv
module pwm_gate_chk #(
   parameter int CNT_W     = 8,
   parameter int DUTY_LIM  = 160,
   parameter int BLANK_CYC = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic [CNT_W-1:0] ctrl_word,
   input logic             gate,
   input logic             cyc_stb,
   input logic [CNT_W-1:0] cnt,
   input logic             dmg_done
);
   localparam logic [CNT_W-1:0] LIM_V   = CNT_W'(DUTY_LIM);
   localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CYC);

   // R2
   stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_stb |=> !cyc_stb);

   // R7
   rise_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate) |-> cyc_stb);

   // R4
   duty_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate |-> (cnt <= LIM_V));

   // R6
   blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && gate && cnt <= BLANK_V && cnt < ctrl_word) |=> gate);

   // R8
   valley_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && cnt == '0 && !dmg_done) |=> (cnt == '0 && !gate));

   // R10
   disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!gate && !cyc_stb && cnt == '0));
endmodule

bind pwm_demag_gate pwm_gate_chk #(
   .CNT_W(CNT_W), .DUTY_LIM(DUTY_LIM), .BLANK_CYC(BLANK_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .ctrl_word(ctrl_word),
   .gate(gate), .cyc_stb(cyc_stb), .cnt(cnt), .dmg_done(dmg_done)
);

// File: tb/test_pwm_demag_gate.sv
module test_pwm_demag_gate;
   localparam int CLK_PERIOD = 10;
   localparam int PERIOD     = 200;
   localparam int DLIM       = 160;
   localparam int BLANK      = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [7:0] ctrl = 8'd0;
   logic       oc_raw = 1'b0;
   logic       zc_raw = 1'b0;
   logic       gate, cyc_stb;

   pwm_demag_gate i_pwm_demag_gate (
      .clk(clk), .rst_n(rst_n), .enable(enable), .ctrl_word(ctrl),
      .oc_async(oc_raw), .zc_async(zc_raw), .gate(gate), .cyc_stb(cyc_stb));

   always #(CLK_PERIOD/2) clk = ~clk;

   int    checks = 0, failures = 0, cyc = 0;
   bit    finished = 0;
   string cur_req = "R1";

   // behavioural reference, advanced on each rising edge
   int m_cnt = 0, m_gate = 0, m_stb = 0, m_done = 1;
   int oc_q[$] = '{0, 0};
   int zc_q[$] = '{0, 0};

   always @(posedge clk) begin
      int st, ng, nc, nd, ocs, zcs;
      if (!rst_n) begin
         m_cnt = 0; m_gate = 0; m_stb = 0; m_done = 1;
         oc_q = '{0, 0}; zc_q = '{0, 0};
      end else begin
         ocs = oc_q[0]; zcs = zc_q[0];
         st  = (enable && m_cnt == 0 && m_done) ? 1 : 0;
         if (!enable) ng = 0;
         else if (st == 1) ng = (ctrl != 0) ? 1 : 0;
         else if (m_gate == 1 && (m_cnt >= ctrl || m_cnt >= DLIM || (ocs == 1 && m_cnt > BLANK))) ng = 0;
         else ng = m_gate;
         if (!enable || (m_cnt == 0 && !m_done) || m_cnt == PERIOD - 1) nc = 0;
         else nc = m_cnt + 1;
         if (st == 1) nd = 0;
         else if (zcs == 1 && m_gate == 0) nd = 1;
         else nd = m_done;
         m_gate = ng; m_cnt = nc; m_done = nd; m_stb = st;
         void'(oc_q.pop_front()); oc_q.push_back(int'(oc_raw));
         void'(zc_q.pop_front()); zc_q.push_back(int'(zc_raw));
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         checks++;
         if (int'(gate) != m_gate || int'(cyc_stb) != m_stb) begin
            failures++;
            if (failures < 12)
               $display("FAIL %s model cycle %0d: gate=%0d stb=%0d expected gate=%0d stb=%0d",
                        cur_req, cyc, gate, cyc_stb, m_gate, m_stb);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1;
         failures++;
         $display("FAIL watchdog expired (all requirements)");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_stb(input int limit, output int got);
      got = 0;
      for (int i = 1; i <= limit; i++) begin
         @(negedge clk);
         if (cyc_stb) begin got = i; return; end
      end
   endtask

   task automatic pulse_width(output int w);
      w = 0;
      while (gate) begin w++; @(negedge clk); end
   endtask

   initial begin
      int got, w, rises;
      repeat (3) @(negedge clk);
      check("R1", int'(gate), 0, "gate in reset");
      check("R1", int'(cyc_stb), 0, "strobe in reset");
      enable = 1'b1; ctrl = 8'd50;
      @(negedge clk); rst_n = 1'b1;

      cur_req = "R1";
      wait_stb(5, got);
      check("R1", got, 1, "first start latency after reset");
      cur_req = "R3";
      pulse_width(w);
      check("R3", w, 50, "on-time equals control word");

      cur_req = "R8";
      rises = 0;
      for (int i = 0; i < 400; i++) begin @(negedge clk); if (cyc_stb) rises++; end
      check("R8", rises, 0, "starts while demag pending");

      cur_req = "R9";
      zc_raw = 1'b1; @(negedge clk); zc_raw = 1'b0;
      wait_stb(10, got);
      check("R9", got, 3, "one-clock zero-crossing latched, start latency");
      check("R11", got, 3, "synchronizer latency on zero-crossing");
      repeat (5) @(negedge clk);
      zc_raw = 1'b1; repeat (10) @(negedge clk); zc_raw = 1'b0;
      pulse_width(w);
      rises = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); if (cyc_stb) rises++; end
      check("R9", rises, 0, "zero-crossing during on-time ignored");

      cur_req = "R2";
      zc_raw = 1'b1;
      wait_stb(10, got);
      wait_stb(400, got);
      check("R2", got, PERIOD, "period with early demag");

      cur_req = "R4";
      ctrl = 8'd255;
      wait_stb(400, got);
      pulse_width(w);
      check("R4", w, DLIM, "duty limit");

      cur_req = "R3";
      ctrl = 8'd0;
      wait_stb(400, got);
      check("R3", int'(gate), 0, "no pulse for zero control");
      rises = 0;
      for (int i = 0; i < 150; i++) begin @(negedge clk); if (gate) rises++; end
      check("R3", rises, 0, "gate cycles for zero control");

      cur_req = "R5";
      ctrl = 8'd150;
      wait_stb(400, got);
      w = 0;
      while (gate) begin w++; if (w == 20) oc_raw = 1'b1; @(negedge clk); end
      check("R5", w, 22, "overcurrent truncated width");
      check("R11", w, 22, "synchronizer latency on overcurrent");
      cur_req = "R7";
      repeat (3) @(negedge clk);
      oc_raw = 1'b0;
      rises = 0;
      for (int i = 0; i < 100; i++) begin @(negedge clk); if (gate) rises++; end
      check("R7", rises, 0, "no second pulse in cycle");

      cur_req = "R6";
      oc_raw = 1'b1;
      wait_stb(400, got);
      pulse_width(w);
      check("R6", w, BLANK + 1, "width with overcurrent held through blanking");
      oc_raw = 1'b0;

      cur_req = "R10";
      ctrl = 8'd100;
      wait_stb(400, got);
      repeat (10) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      check("R10", int'(gate), 0, "gate after disable");
      rises = 0;
      for (int i = 0; i < 50; i++) begin @(negedge clk); if (gate || cyc_stb) rises++; end
      check("R10", rises, 0, "activity while disabled");
      enable = 1'b1;
      wait_stb(3, got);
      check("R10", got, 1, "restart latency after enable");
      pulse_width(w);
      check("R3", w, 100, "on-time after restart");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule